// File: doc/BRIEF.md
# BERT Received-Pattern Snapshot Register

This block belongs to the receive side of a bit error rate tester. It keeps a running window of the last 32 received serial bits. When a latch request arrives it copies a 32-bit word into a snapshot register. The word it copies depends on the receiver's lock state. While the receiver is not locked, the snapshot takes the raw window of received bits. Once the receiver is locked, the snapshot takes the reference word that the pattern synchroniser reports as locked, so bit errors on the line never show up in it.

A latch request can come from a software control bit or from an external pin. The two are ORed, and only a rising edge of the combined request triggers a capture. Pattern detection, reference generation and error counting sit outside this block and appear here only as inputs.

Software reads the snapshot as four byte registers through a plain address/read port. The snapshot has no fixed alignment to the start of the pattern, so any rotation of the pattern is a valid result. The serial input is a plain strobe: each cycle with `rx_valid` high delivers exactly one bit. The block never applies back-pressure and never drops a strobed bit.

Top module: `bert_snap_capture`

## Requirements
- R1: The snapshot is read as four bytes at addresses 0x10, 0x11, 0x12 and 0x13. Address 0x10 returns bits 31..24 and address 0x13 returns bits 7..0. Read data is combinational from `rd_addr` while `rd_en` is high.
- R2: In every cycle with `rx_valid` high, the receive window shifts left by one and `rx_bit` enters at bit 0. Cycles with `rx_valid` low leave the window unchanged. When a capture happens with `sync_ok` at 0, the snapshot takes the window.
- R3: When a capture happens with `sync_ok` at 1, the snapshot takes `ref_word` regardless of the received bits. Line errors therefore never appear in the snapshot.
- R4: `ctl_latch` and `pin_latch` each trigger a capture on their own. Both rising in the same cycle give a single capture.
- R5: A capture happens only on a 0-to-1 transition of (`ctl_latch` OR `pin_latch`). Holding the request high captures only once.
- R6: When no capture happens, the snapshot keeps its value whatever the serial data, the sync flag or the reference word do.
- R7: Reset (`rst_n` low) clears the receive window and all four snapshot bytes to zero.
- R8: A read returns 0 when `rd_en` is low or when `rd_addr` lies outside 0x10..0x13.
- R9: A capture at a clock edge takes the window as it stood before that edge. A bit strobed in the same cycle as the capture is not part of the snapshot. The new snapshot is readable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_valid | input | 1 | Strobe: `rx_bit` carries one bit this cycle |
| sync_ok | input | 1 | Receiver lock flag, 1 = locked |
| ref_word | input | 32 | Reference pattern word that the receiver is locked to |
| ctl_latch | input | 1 | Latch request from a control register bit |
| pin_latch | input | 1 | Latch request from an external pin |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data byte |

## Verification
A corrupt receive window shows up only through a capture made while unlocked, so the bench captures known bit runs and reads all four bytes in the next cycle. A stuck edge detector shows up in two ways: as an extra capture while a request is held high, or as a missing capture when the pin alone rises. Random traffic mixes captures in both lock states with reads at random addresses. This exposes a wrong source select, a wrong byte order or a snapshot that drifts within one cycle of the faulty capture.

// File: rtl/bert_cap_pkg.sv
package bert_cap_pkg;
  localparam int SNAP_W = 32;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int N_BYTES = SNAP_W / BYTE_W;
  localparam logic [ADDR_W-1:0] SNAP_BASE = 8'h10;
endpackage

// File: rtl/bcap_rx_shift.sv
module bcap_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_i,
  input  logic         valid_i,
  output logic [W-1:0] window_o
);
  logic [W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (valid_i) begin
      win_q <= {win_q[W-2:0], bit_i};
    end
  end

  assign window_o = win_q;
endmodule

// File: rtl/bcap_req_edge.sv
module bcap_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_i,
  input  logic pin_i,
  output logic fire_o
);
  logic req_w;
  logic req_prev_q;

  assign req_w = ctl_i | pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
    end else begin
      req_prev_q <= req_w;
    end
  end

  assign fire_o = req_w & ~req_prev_q;
endmodule

// File: rtl/bcap_snap_bank.sv
module bcap_snap_bank #(
  parameter int              W      = 32,
  parameter int              BYTE_W = 8,
  parameter int              AW     = 8,
  parameter logic [AW-1:0]   BASE   = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              sync_i,
  input  logic [W-1:0]      live_i,
  input  logic [W-1:0]      ref_i,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [W-1:0]      snap_o
);
  localparam int NB = W / BYTE_W;

  logic [W-1:0] snap_q;
  logic [NB-1:0][BYTE_W-1:0] hit_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (fire_i) begin
      snap_q <= sync_i ? ref_i : live_i;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [AW-1:0] ADDR_K = AW'(int'(BASE) + k);
    assign hit_bytes[k] = (rd_en && rd_addr == ADDR_K)
                          ? snap_q[W-1-BYTE_W*k -: BYTE_W] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NB; k++) begin
      rd_data = rd_data | hit_bytes[k];
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/bert_snap_capture.sv
module bert_snap_capture
  import bert_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_valid,
  input  logic              sync_ok,
  input  logic [SNAP_W-1:0] ref_word,
  input  logic              ctl_latch,
  input  logic              pin_latch,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [SNAP_W-1:0] window_w;
  logic [SNAP_W-1:0] snap_w;
  logic              fire_w;

  bcap_rx_shift #(.W(SNAP_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_i    (rx_bit),
    .valid_i  (rx_valid),
    .window_o (window_w)
  );

  bcap_req_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_i  (ctl_latch),
    .pin_i  (pin_latch),
    .fire_o (fire_w)
  );

  bcap_snap_bank #(
    .W(SNAP_W), .BYTE_W(BYTE_W), .AW(ADDR_W), .BASE(SNAP_BASE)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire_w),
    .sync_i  (sync_ok),
    .live_i  (window_w),
    .ref_i   (ref_word),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .snap_o  (snap_w)
  );
endmodule

// File: rtl/bert_snap_capture_chk.sv
module bert_snap_capture_chk
  import bert_cap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_bit,
  input logic              rx_valid,
  input logic              sync_ok,
  input logic [SNAP_W-1:0] ref_word,
  input logic              ctl_latch,
  input logic              pin_latch,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [SNAP_W-1:0] window_w,
  input logic [SNAP_W-1:0] snap_w
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(int'(SNAP_BASE) + N_BYTES - 1);

  logic req_c;
  logic prev_c;
  logic rise_c;
  logic oor_c;

  assign req_c  = ctl_latch | pin_latch;
  assign rise_c = req_c & ~prev_c;
  assign oor_c  = (rd_addr < SNAP_BASE) || (rd_addr > LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_c <= 1'b0;
    else        prev_c <= req_c;
  end

  AST_UNSYNC_TAKES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c && !sync_ok) |=> snap_w == $past(window_w)); // R2
  AST_WINDOW_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> window_w[SNAP_W-1:1] == $past(window_w[SNAP_W-2:0])); // R2
  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(window_w)); // R2
  AST_SYNC_TAKES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c && sync_ok) |=> snap_w == $past(ref_word)); // R3
  AST_HELD_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_c && prev_c) |=> $stable(snap_w)); // R5
  AST_IDLE_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_c |=> $stable(snap_w)); // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || oor_c) |-> rd_data == '0); // R8
endmodule

bind bert_snap_capture bert_snap_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
  .sync_ok(sync_ok), .ref_word(ref_word), .ctl_latch(ctl_latch),
  .pin_latch(pin_latch), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .window_w(window_w), .snap_w(snap_w)
);

// File: tb/bert_snap_capture_tb.sv
module bert_snap_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0;
  logic        rx_valid = 1'b0;
  logic        sync_ok = 1'b0;
  logic [31:0] ref_word = '0;
  logic        ctl_latch = 1'b0;
  logic        pin_latch = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_win = '0;
  logic [31:0] m_snap = '0;
  logic        m_prev = 1'b0;

  always #4 clk = ~clk;

  bert_snap_capture u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .sync_ok(sync_ok), .ref_word(ref_word), .ctl_latch(ctl_latch),
    .pin_latch(pin_latch), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_rd(input logic en, input logic [7:0] a);
    if (!en || a < 8'h10 || a > 8'h13) return 8'h00;
    return m_snap[31 - 8*(a - 8'h10) -: 8];
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h expected %02h", tag, got, exp);
    end
  endtask

  // One clock cycle: drive at negedge, check read, then update the model at posedge.
  task automatic cyc(input logic b, input logic v, input logic s, input logic [31:0] rw,
                     input logic c, input logic p, input logic e, input logic [7:0] a,
                     input string tag);
    @(negedge clk);
    rx_bit = b; rx_valid = v; sync_ok = s; ref_word = rw;
    ctl_latch = c; pin_latch = p; rd_en = e; rd_addr = a;
    #1;
    if (e || tag != "") chk(tag, rd_data, exp_rd(e, a));
    @(posedge clk);
    if ((c | p) && !m_prev) m_snap = s ? rw : m_win;
    if (v) m_win = {m_win[30:0], b};
    m_prev = c | p;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 4; k++)
      cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'(8'h10 + k), tag);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 31; k >= 0; k--)
      cyc(w[k], 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, "");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R7: reset contents
    read_all("R7 reset zero");

    // R1, R2: capture of the receive window while unlocked
    send_word(32'hA5C3_1E72);
    cyc(1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 8'h00, "");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h10, "R1 byte 0x10");
    chk("R1 literal msb", rd_data, 8'hA5);
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h13, "R1 byte 0x13");
    chk("R2 literal lsb", rd_data, 8'h72);
    read_all("R2 window capture");

    // R2: strobe low leaves the window unchanged
    for (int k = 0; k < 10; k++)
      cyc(k[0], 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, "");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, "");
    idle("");
    read_all("R2 no strobe no shift");

    // R5: held request captures once
    send_word(32'h1357_9BDF);
    for (int k = 0; k < 8; k++)
      cyc(~k[1], 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 8'h00, "");
    read_all("R5 held request");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h11, "R5 literal");
    chk("R5 literal 0x11", rd_data, 8'h57);

    // R3, R4: pin alone while locked, line bits ignored
    cyc(1'b1, 1'b1, 1'b1, 32'h0F1E_2D3C, 1'b0, 1'b1, 1'b0, 8'h00, "");
    cyc(1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 8'h00, "");
    read_all("R3 locked takes reference");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h12, "R3 byte");
    chk("R3 literal 0x12", rd_data, 8'h2D);

    // R4: both sources rise together
    send_word(32'hC0FF_EE01);
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 8'h00, "");
    idle("");
    read_all("R4 both sources");

    // R9: bit strobed in the capture cycle is excluded
    send_word(32'h8000_0001);
    cyc(1'b1, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 8'h13, "R9 before capture");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h13, "R9 next cycle");
    chk("R9 literal 0x13", rd_data, 8'h01);

    // R6: no request, busy inputs
    for (int k = 0; k < 40; k++)
      cyc(1'($urandom), 1'b1, 1'($urandom), $urandom, 1'b0, 1'b0, 1'b0, 8'h00, "");
    read_all("R6 stable without request");

    // R8: out of range and disabled reads
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h0F, "R8 addr 0x0F");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, "R8 addr 0x14");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'hFF, "R8 addr 0xFF");
    cyc(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h10, "R8 rd_en low");

    // Random mix of all requirements
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      a = ($urandom % 4 != 0) ? 8'(8'h10 + $urandom % 4) : 8'($urandom);
      cyc(1'($urandom), ($urandom % 4 != 0), 1'($urandom), $urandom,
          ($urandom % 6 == 0), ($urandom % 8 == 0), ($urandom % 5 != 0), a,
          "R1 R2 R3 R4 R5 R8 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule